// File: doc/BRIEF.md
# Windowed Watchdog Timer with Status Flags

This block is a supervision timer for a system-basis controller. Firmware must service it by writing a clear strobe, and it may only do so inside a window. The window stays shut for the first half of each period and opens for the second half. If the period runs out, or if a clear arrives while the window is shut, the block requests a one-cycle reset and records why in a sticky timeout flag. The flag stays set until firmware reads the status register or accesses the timing control register.

Two health inputs change how the block behaves. When the external timing reference is reported missing, an error flag is raised. The timer then counts on an internal tick that is four times coarser, and windowing is switched off, so clears are accepted at any point. When a configuration strap disables the watchdog, an off flag is raised and no reset is ever requested. A four-bit status word collects the flags. The same word serves as the reply to a timing-register write.

Top module: `window_watchdog`

## Requirements
- R1: After power-on reset `rstReq` is 0, `status` is 4'b0000 (with the reference present and the strap inactive) and `windowOpen` is 0.
- R2: A tick lasts TICK_DIV clocks. The period is P = BASE_TICKS*(periodSel+1) ticks and starts at a restart. `windowOpen` reads 0 for the first P/2 ticks and 1 from tick P/2 onward.
- R3: If no valid clear arrives, `rstReq` is high for exactly one clock, P ticks after the restart. The period then restarts with the window closed.
- R4: A clear while `windowOpen` is 0, with the reference present and the strap inactive, raises `rstReq` on the next clock and sets the timeout flag.
- R5: A clear while `windowOpen` is 1 restarts the period and causes no reset. This also holds in the last clock before expiry.
- R6: The timeout flag is `status[3]`. It is set on every reset request and held until a `statusRd` or `timingAcc` pulse clears it one clock later. When a set and a clear fall in the same clock, the set wins.
- R7: While `refPresent` is 0, `status[2]` is 1 and a tick lasts 4*TICK_DIV clocks. A clear at any point restarts the period without a reset.
- R8: While `pinDisable` is 1, `status[1]` is 1, `rstReq` stays 0, `windowOpen` stays 0 and clears have no effect.
- R9: Status bit order: [3] timeout, [2] reference error, [1] strap off, [0] window open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| clearStb | input | 1 | Watchdog clear write, one clock |
| statusRd | input | 1 | Status register read strobe |
| timingAcc | input | 1 | Timing control register access strobe |
| periodSel | input | SEL_W | Period select |
| refPresent | input | 1 | External timing reference detected |
| pinDisable | input | 1 | Strap disables watchdog |
| rstReq | output | 1 | One-clock reset request |
| status | output | 4 | {timeout, error, off, windowOpen} |
| windowOpen | output | 1 | Clear window open |

## Verification
Every period select is swept. Window opening and expiry are timed from a reset pulse. Clears are placed in the last closed cycle, in the first open cycle, and in the cycle before expiry. This separates an off-by-one in the window edge from one in the expiry edge, and shows that a clear takes priority over expiry. With the reference missing, a clear in the closed half is tried and the coarse timing is measured. With the strap active, periodic clears must not cause a reset. The flag clear is driven through each access strobe, and once together with an expiry, to show that a set outranks a clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from control to datapath and flag logic
  typedef struct packed {
    logic restart;     // zero prescaler and tick counter
    logic fireReset;   // request a reset this cycle
    logic setTimeout;  // latch the timeout flag
    logic clrTimeout;  // status or timing access
  } wdtCtrl_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath #(
  parameter int TICK_DIV    = 4,
  parameter int BASE_TICKS  = 8,
  parameter int SEL_W       = 2,
  parameter int COARSE_MULT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hold,
  input  logic             coarse,
  input  logic [SEL_W-1:0] periodSel,
  input  wdt_pkg::wdtCtrl_t ctrl,
  output logic             windowOpen,
  output logic             expire
);
  localparam int MAX_SEL   = (1 << SEL_W) - 1;
  localparam int MAX_TICKS = BASE_TICKS * (MAX_SEL + 1);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int PRE_MAX   = TICK_DIV * COARSE_MULT;
  localparam int PRE_W     = $clog2(PRE_MAX + 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] periodTicks;
  logic [CNT_W-1:0] halfTicks;
  logic             tick;

  // Prescaler limit: the fine tick, or the coarse fallback tick
  assign preLimit    = coarse ? PRE_W'(PRE_MAX - 1) : PRE_W'(TICK_DIV - 1);
  assign tick        = !hold && (preCnt >= preLimit);
  assign periodTicks = CNT_W'(BASE_TICKS) * (CNT_W'(periodSel) + CNT_W'(1));
  assign halfTicks   = periodTicks >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (hold || ctrl.restart) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (tick) begin
      preCnt  <= '0;
      if (tickCnt != {CNT_W{1'b1}}) tickCnt <= tickCnt + CNT_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  assign windowOpen = !hold && (tickCnt >= halfTicks);
  // >= keeps expiry reachable after the period select shrinks mid-period
  assign expire     = tick && (tickCnt >= periodTicks - CNT_W'(1));
endmodule

// File: rtl/wdt_control.sv
module wdt_control (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearStb,
  input  logic              statusRd,
  input  logic              timingAcc,
  input  logic              windowOpen,
  input  logic              expire,
  input  logic              refMissing,
  input  logic              pinOff,
  output wdt_pkg::wdtCtrl_t ctrl,
  output logic              rstReq,
  output logic              timeoutFlag
);
  logic accepted;
  logic early;
  logic fire;

  // A clear is accepted inside the window, or at any time when windowing is off
  assign accepted = clearStb && !pinOff && (refMissing || windowOpen);
  assign early    = clearStb && !pinOff && !refMissing && !windowOpen;
  // An accepted clear outranks an expiry in the same cycle
  assign fire     = !pinOff && !accepted && (expire || early);

  always_comb begin
    ctrl.fireReset  = fire;
    ctrl.restart    = fire || accepted;
    ctrl.setTimeout = fire;
    ctrl.clrTimeout = statusRd || timingAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq      <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      rstReq <= ctrl.fireReset;
      if (ctrl.setTimeout)      timeoutFlag <= 1'b1;
      else if (ctrl.clrTimeout) timeoutFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int TICK_DIV   = 4,
  parameter int BASE_TICKS = 8,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             clearStb,
  input  logic             statusRd,
  input  logic             timingAcc,
  input  logic [SEL_W-1:0] periodSel,
  input  logic             refPresent,
  input  logic             pinDisable,
  output logic             rstReq,
  output logic [3:0]       status,
  output logic             windowOpen
);
  wdt_pkg::wdtCtrl_t ctrl;
  logic expire;
  logic timeoutFlag;

  wdt_datapath #(
    .TICK_DIV(TICK_DIV), .BASE_TICKS(BASE_TICKS), .SEL_W(SEL_W), .COARSE_MULT(4)
  ) u_dp (
    .clk(clk), .rstN(porN), .hold(pinDisable), .coarse(!refPresent),
    .periodSel(periodSel), .ctrl(ctrl), .windowOpen(windowOpen), .expire(expire)
  );

  wdt_control u_ctl (
    .clk(clk), .rstN(porN), .clearStb(clearStb), .statusRd(statusRd),
    .timingAcc(timingAcc), .windowOpen(windowOpen), .expire(expire),
    .refMissing(!refPresent), .pinOff(pinDisable), .ctrl(ctrl),
    .rstReq(rstReq), .timeoutFlag(timeoutFlag)
  );

  assign status = {timeoutFlag, !refPresent, pinDisable, windowOpen};
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       porN,
  input logic       clearStb,
  input logic       refPresent,
  input logic       pinDisable,
  input logic       rstReq,
  input logic       windowOpen,
  input logic [3:0] status
);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!porN)
    rstReq |=> !rstReq);

  assert_closed_clear_R4: assert property (@(posedge clk) disable iff (!porN)
    clearStb && !windowOpen && refPresent && !pinDisable |=> rstReq);

  assert_open_clear_R5: assert property (@(posedge clk) disable iff (!porN)
    clearStb && windowOpen && !pinDisable |=> !rstReq);

  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!porN)
    $rose(status[3]) |-> rstReq);

  assert_flag_on_reset_R6: assert property (@(posedge clk) disable iff (!porN)
    rstReq |-> status[3]);

  assert_no_reject_R7: assert property (@(posedge clk) disable iff (!porN)
    clearStb && !refPresent && !pinDisable |=> !rstReq);

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!porN)
    pinDisable && $past(pinDisable) |-> !rstReq && !windowOpen);
endmodule

bind window_watchdog wdt_checker u_chk (
  .clk(clk), .porN(porN), .clearStb(clearStb), .refPresent(refPresent),
  .pinDisable(pinDisable), .rstReq(rstReq), .windowOpen(windowOpen),
  .status(status)
);

// File: tb/window_watchdog_test.sv
module window_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int BASE = 8;
  localparam int SW   = 2;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic clearStb = 1'b0, statusRd = 1'b0, timingAcc = 1'b0;
  logic [SW-1:0] periodSel = '0;
  logic refPresent = 1'b1, pinDisable = 1'b0;
  logic rstReq, windowOpen;
  logic [3:0] status;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  window_watchdog #(.TICK_DIV(TDIV), .BASE_TICKS(BASE), .SEL_W(SW)) uut (
    .clk(clk), .porN(porN), .clearStb(clearStb), .statusRd(statusRd),
    .timingAcc(timingAcc), .periodSel(periodSel), .refPresent(refPresent),
    .pinDisable(pinDisable), .rstReq(rstReq), .status(status),
    .windowOpen(windowOpen));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Leaves the bench at the falling edge right after a reset request rose
  task automatic syncToReset();
    int lim = 0;
    do begin
      @(negedge clk);
      lim++;
    end while (!rstReq && lim < 5000);
    check(rstReq == 1'b1, "R3 sync", int'(rstReq), 1);
  endtask

  task automatic pulseClear();
    clearStb = 1'b1; stepN(1); clearStb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    stepN(3);
    // R1 / R9 reset state
    check(rstReq == 1'b0, "R1 rstReq", int'(rstReq), 0);
    check(status == 4'b0000, "R1 status", int'(status), 0);
    porN = 1'b1;
    stepN(2);
    check(windowOpen == 1'b0 && status == 4'b0000, "R1 after release", int'(status), 0);

    // Sweep every period select with the fine tick
    for (int sel = 0; sel < (1 << SW); sel++) begin
      int p, h;
      p = BASE * (sel + 1);
      h = p / 2;
      periodSel = SW'(sel);
      syncToReset();
      stepN(h * TDIV - 1);
      check(windowOpen == 1'b0, "R2 last closed", int'(windowOpen), 0);
      stepN(1);
      check(windowOpen == 1'b1, "R2 first open", int'(windowOpen), 1);
      check(status[0] == 1'b1, "R9 window bit", int'(status[0]), 1);
      stepN(p * TDIV - h * TDIV - 1);
      check(rstReq == 1'b0, "R3 before expiry", int'(rstReq), 0);
      stepN(1);
      check(rstReq == 1'b1, "R3 expiry", int'(rstReq), 1);
      check(status[3] == 1'b1, "R6 flag set by timeout", int'(status[3]), 1);
      stepN(1);
      check(rstReq == 1'b0, "R3 single pulse", int'(rstReq), 0);
      check(windowOpen == 1'b0, "R3 restart closed", int'(windowOpen), 0);

      // R4: clear in the last closed cycle
      syncToReset();
      statusRd = 1'b1; stepN(1); statusRd = 1'b0;
      check(status[3] == 1'b0, "R6 cleared by status read", int'(status[3]), 0);
      stepN(10);
      check(status[3] == 1'b0, "R6 stays clear", int'(status[3]), 0);
      stepN(h * TDIV - 12);
      pulseClear();
      check(rstReq == 1'b1, "R4 early clear", int'(rstReq), 1);
      check(status[3] == 1'b1, "R4 flag set", int'(status[3]), 1);

      // R5: clear in the first open cycle; new period counts from the clear
      stepN(h * TDIV);
      check(windowOpen == 1'b1, "R5 open before clear", int'(windowOpen), 1);
      pulseClear();
      check(rstReq == 1'b0 && windowOpen == 1'b0, "R5 accepted clear",
            int'({rstReq, windowOpen}), 0);
      stepN(h * TDIV - 1);
      check(windowOpen == 1'b0, "R5 restarted window", int'(windowOpen), 0);
      stepN(1);
      check(windowOpen == 1'b1, "R5 reopened", int'(windowOpen), 1);
      // R5: clear in the cycle of expiry
      stepN(p * TDIV - h * TDIV - 1);
      pulseClear();
      check(rstReq == 1'b0, "R5 clear beats expiry", int'(rstReq), 0);
    end

    // R6: timing access clears the flag; set outranks same-cycle clear
    periodSel = 2'd0;
    syncToReset();
    timingAcc = 1'b1; stepN(1); timingAcc = 1'b0;
    check(status[3] == 1'b0, "R6 cleared by timing access", int'(status[3]), 0);
    stepN(BASE * TDIV - 2);
    statusRd = 1'b1; stepN(1); statusRd = 1'b0;
    check(rstReq == 1'b1 && status[3] == 1'b1, "R6 set wins", int'(status[3]), 1);

    // R7: missing reference, coarse tick and no window
    refPresent = 1'b0;
    periodSel = 2'd1;
    stepN(1);
    check(status[2] == 1'b1, "R7 error bit", int'(status[2]), 1);
    syncToReset();
    stepN(3);
    pulseClear();
    check(rstReq == 1'b0, "R7 closed clear accepted", int'(rstReq), 0);
    stepN(8 * TDIV * 4 - 1);
    check(windowOpen == 1'b0, "R7 coarse half", int'(windowOpen), 0);
    stepN(1);
    check(windowOpen == 1'b1, "R7 coarse open", int'(windowOpen), 1);
    stepN(8 * TDIV * 4 - 1);
    check(rstReq == 1'b0, "R7 before coarse expiry", int'(rstReq), 0);
    stepN(1);
    check(rstReq == 1'b1, "R7 coarse expiry", int'(rstReq), 1);
    refPresent = 1'b1;

    // R8: strap disables everything
    periodSel = 2'd0;
    pinDisable = 1'b1;
    stepN(1);
    check(status[1] == 1'b1, "R8 off bit", int'(status[1]), 1);
    begin
      int bad = 0;
      for (int i = 0; i < 800; i++) begin
        if (i % 37 == 5) clearStb = 1'b1;
        stepN(1);
        clearStb = 1'b0;
        if (rstReq || windowOpen) bad++;
      end
      check(bad == 0, "R8 no reset or window", bad, 0);
    end
    pinDisable = 1'b0;
    stepN(1);
    check(status[1] == 1'b0, "R9 off bit cleared", int'(status[1]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule